// File: doc/BRIEF.md
# Double-Buffered Quad Converter Code Register Bank

This block is the digital front end of a four-channel, 8-bit converter. It is modelled in one synchronous clock domain. Each channel holds its code in two stages. The first stage is a staging register that is written through a parallel bus. The second stage is an active register that drives the channel's code. A 2-bit channel select chooses which staging register an active-low write strobe updates. A separate active-low load control copies all four staging registers into their active registers in the same clock cycle, so every channel moves at once.

While a control input is held active, the register it controls is rewritten on every clock. This is how the model represents a transparent latch. When the write strobe and the load control are active together, a word on the bus flows through the addressed staging register into its active register in a single update. A shutdown input disables all four outputs without disturbing the stored codes. Besides the codes, each channel drives an output-enable flag and a millivolt-equivalent value, code × REF_MV / 256, which a checker can compare against an analog expectation.

Top module: `quad_dac_regbank`

## Requirements
- R1: `addr` selects the channel: 0 is channel A, 1 is B, 2 is C and 3 is D. Channel i uses bits [8i+7:8i] of `dac_code` and bits [12i+11:12i] of `level_mv`. A write never touches more than one staging register.
- R2: On each clock where `wr_n` is low, the addressed staging register takes `din`. Where `wr_n` is high, every staging register keeps its value.
- R3: On each clock where `ld_n` is low, all four active registers copy their staging registers. Where `ld_n` is high, the active registers hold, whatever is written.
- R4: When `wr_n` and `ld_n` are low together, `din` reaches the addressed channel's active register in the same update, with the same latency as a plain load.
- R5: When `wr_n` and `ld_n` are both high, changes on `addr` and `din` have no effect on any output.
- R6: A synchronous reset sets every staging register and active register to 0x00. After reset, `dac_code` and `level_mv` read 0 and `out_en` reads all ones.
- R7: While `shdn` is high, `out_en` is 0 for every channel and `dac_code` and `level_mv` read 0. Both register stages keep their contents. When `shdn` returns low, the stored codes appear again.
- R8: `level_mv` for a channel equals floor(code × REF_MV / 256) while that channel is enabled, with REF_MV = 3300.
- R9: Every input passes through two synchronizing flops. An input applied before clock edge k shows its effect on the outputs after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe for the addressed staging register, active low |
| ld_n | input | 1 | Broadcast load from staging to active registers, active low |
| shdn | input | 1 | Shutdown, active high |
| addr | input | 2 | Channel select |
| din | input | 8 | Parallel data word |
| dac_code | output | 32 | Active codes of the four channels, channel A in the low byte |
| out_en | output | 4 | Per-channel output enable |
| level_mv | output | 48 | Millivolt-equivalent level per channel, 12 bits each |

## Verification
Several properties are checked by assertions on every cycle: that a write selects at most one channel, that a staging register holds while it is unselected, and that the active registers hold while the load is idle. The assertions also check that the active registers copy their staging values, or `din` directly, while the load is active, that shutdown forces the outputs off, and that reset clears them. Other behaviours need the bench's scenarios to become visible at the ports. These are the restoration of stored codes after shutdown, the inertness of the bus when both controls are idle, the exact three-edge latency, and the millivolt scaling across random codes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Control inputs bundled so they travel through one synchronizer.
  typedef struct packed {
    logic wr_n;
    logic ld_n;
    logic shdn;
  } qdac_ctrl_t;

  // Idle levels: strobes released, shutdown off.
  localparam qdac_ctrl_t CTRL_IDLE = '{wr_n: 1'b1, ld_n: 1'b1, shdn: 1'b0};

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int            WIDTH   = 1,
  parameter int            STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic              ld,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] active_q
);

  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] stage_next;

  // A selected write makes the staging value visible to the load in the same update.
  always_comb begin
    stage_next = wr_sel ? din : stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      stage_q <= stage_next;
      if (ld) active_q <= stage_next;
    end
  end

  a_r2_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(stage_q));

  a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(active_q));

  a_r3_load_copy: assert property (@(posedge clk) disable iff (rst)
    (ld && !wr_sel) |=> (active_q == $past(stage_q)));

  a_r4_flow_through: assert property (@(posedge clk) disable iff (rst)
    (ld && wr_sel) |=> (active_q == $past(din)));

endmodule

// File: rtl/qdac_scale.sv
module qdac_scale #(
  parameter int CODE_W = 8,
  parameter int REF_MV = 3300,
  parameter int MV_W   = 12
) (
  input  logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   level
);

  localparam int PROD_W = CODE_W + MV_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod  = PROD_W'(code) * PROD_W'(REF_MV);
    level = MV_W'(prod >> CODE_W);
  end

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter int CHANNELS = 4,
  parameter int CODE_W   = 8,
  parameter int REF_MV   = 3300,
  parameter int SYNC_STG = 2,
  localparam int ADDR_W  = $clog2(CHANNELS),
  localparam int MV_W    = $clog2(REF_MV + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_n,
  input  logic                       ld_n,
  input  logic                       shdn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CODE_W-1:0]          din,
  output logic [CHANNELS*CODE_W-1:0] dac_code,
  output logic [CHANNELS-1:0]        out_en,
  output logic [CHANNELS*MV_W-1:0]   level_mv
);

  import qdac_pkg::*;

  localparam int BUS_W = ADDR_W + CODE_W;

  qdac_ctrl_t          ctrl_raw;
  qdac_ctrl_t          ctrl_s;
  logic [BUS_W-1:0]    bus_s;
  logic [ADDR_W-1:0]   addr_s;
  logic [CODE_W-1:0]   din_s;
  logic [CHANNELS-1:0] wr_sel;
  logic                ld_s;
  logic                shdn_d;

  always_comb begin
    ctrl_raw.wr_n = wr_n;
    ctrl_raw.ld_n = ld_n;
    ctrl_raw.shdn = shdn;
  end

  qdac_sync #(.WIDTH($bits(qdac_ctrl_t)), .STAGES(SYNC_STG), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctrl_raw),
    .q   (ctrl_s)
  );

  // Bus goes through the same depth so it stays aligned with the strobes.
  qdac_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({addr, din}),
    .q   (bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:CODE_W];
  assign din_s  = bus_s[CODE_W-1:0];
  assign ld_s   = ~ctrl_s.ld_n;

  // Shutdown delayed one cycle to line up with the active register update.
  always_ff @(posedge clk) begin
    if (rst) shdn_d <= 1'b0;
    else     shdn_d <= ctrl_s.shdn;
  end

  genvar i;
  generate
    for (i = 0; i < CHANNELS; i++) begin : g_ch
      logic [CODE_W-1:0] active;
      logic [MV_W-1:0]   level;

      assign wr_sel[i] = ~ctrl_s.wr_n && (addr_s == ADDR_W'(i));

      qdac_channel #(.CODE_W(CODE_W)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel[i]),
        .ld       (ld_s),
        .din      (din_s),
        .active_q (active)
      );

      qdac_scale #(.CODE_W(CODE_W), .REF_MV(REF_MV), .MV_W(MV_W)) u_scale (
        .code  (active),
        .level (level)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          dac_code[i*CODE_W +: CODE_W] <= '0;
          level_mv[i*MV_W +: MV_W]     <= '0;
          out_en[i]                    <= 1'b1;
        end else begin
          dac_code[i*CODE_W +: CODE_W] <= shdn_d ? '0 : active;
          level_mv[i*MV_W +: MV_W]     <= shdn_d ? '0 : level;
          out_en[i]                    <= ~shdn_d;
        end
      end
    end
  endgenerate

  a_r1_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  a_r7_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    shdn_d |=> (out_en == '0 && dac_code == '0 && level_mv == '0));

  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && level_mv == '0 && out_en == '1));

endmodule

// File: tb/quad_dac_regbank_test.sv
module quad_dac_regbank_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_n, ld_n, shdn;
  logic [1:0]  addr;
  logic [7:0]  din;
  logic [31:0] dac_code;
  logic [3:0]  out_en;
  logic [47:0] level_mv;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5ns clk = ~clk;

  quad_dac_regbank uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .ld_n(ld_n), .shdn(shdn),
    .addr(addr), .din(din), .dac_code(dac_code), .out_en(out_en), .level_mv(level_mv)
  );

  // Bench model state
  logic [7:0]  m_stage [4];
  logic [7:0]  m_act   [4];
  logic [7:0]  e_code  [4];
  logic [3:0]  e_en;
  logic        m_sh_d;
  logic [12:0] p1, p2; // {wr_n, ld_n, shdn, addr, din} after sync stage 1 and 2

  function automatic logic [11:0] mv_of(input logic [7:0] c);
    return 12'((32'(c) * 32'd3300) / 32'd256);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      m_stage[k] = '0; m_act[k] = '0; e_code[k] = '0;
    end
    e_en = 4'hF; m_sh_d = 1'b0;
    p1 = {3'b110, 10'd0}; p2 = p1;
  endtask

  task automatic model_edge(input logic [12:0] cur);
    logic w, l;
    logic [1:0] a;
    logic [7:0] d;
    for (int k = 0; k < 4; k++) e_code[k] = m_sh_d ? 8'h00 : m_act[k];
    e_en = m_sh_d ? 4'h0 : 4'hF;
    m_sh_d = p2[10];
    w = p2[12]; l = p2[11]; a = p2[9:8]; d = p2[7:0];
    for (int k = 0; k < 4; k++) begin
      if (!w && a == 2'(k)) m_stage[k] = d;
      if (!l) m_act[k] = m_stage[k];
    end
    p2 = p1; p1 = cur;
  endtask

  task automatic check(input string tag);
    logic [31:0] ec;
    logic [47:0] em;
    for (int k = 0; k < 4; k++) begin
      ec[k*8 +: 8]  = e_code[k];
      em[k*12 +: 12] = mv_of(e_code[k]);
    end
    n_checks++;
    if (dac_code !== ec || out_en !== e_en || level_mv !== em) begin
      n_fail++;
      $display("FAIL %s: code=%h en=%h mv=%h expected code=%h en=%h mv=%h",
               tag, dac_code, out_en, level_mv, ec, e_en, em);
    end
  endtask

  task automatic step(input logic w, input logic l, input logic s,
                      input logic [1:0] a, input logic [7:0] d, input string tag);
    wr_n = w; ld_n = l; shdn = s; addr = a; din = d;
    @(posedge clk);
    if (rst) model_reset();
    else     model_edge({w, l, s, a, d});
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b1, 1'b1, shdn, addr, din, tag);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; wr_n = 1'b1; ld_n = 1'b1; shdn = 1'b0; addr = '0; din = '0;
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R6 reset");
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R6 reset");
    rst = 1'b0;
    idle(3, "R6 after reset");

    // R1/R2: write each channel with load idle; R3 outputs must hold
    step(1'b0, 1'b1, 1'b0, 2'd0, 8'h11, "R3 hold A");
    step(1'b0, 1'b1, 1'b0, 2'd1, 8'h22, "R3 hold B");
    step(1'b0, 1'b1, 1'b0, 2'd2, 8'h33, "R3 hold C");
    step(1'b0, 1'b1, 1'b0, 2'd3, 8'hF4, "R3 hold D");
    idle(3, "R3 no load");
    // R3: one load pulse moves all four together; R9 latency observed per cycle
    step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R3 broadcast load");
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R9 latency 1");
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R9 latency 2");
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R1 channel order after load");
    idle(2, "R8 levels");

    // R2: strobe held low, data changing each cycle; last value wins
    step(1'b0, 1'b1, 1'b0, 2'd2, 8'h01, "R2 follow");
    step(1'b0, 1'b1, 1'b0, 2'd2, 8'h02, "R2 follow");
    step(1'b0, 1'b1, 1'b0, 2'd2, 8'hAB, "R2 follow");
    step(1'b1, 1'b1, 1'b0, 2'd2, 8'h77, "R2 held");
    step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R2 load shows last");
    idle(4, "R2 result");

    // R4: both low, data flows straight through
    step(1'b0, 1'b0, 1'b0, 2'd1, 8'hFF, "R4 flow through");
    step(1'b1, 1'b1, 1'b0, 2'd1, 8'h00, "R4 flow through");
    idle(3, "R4 result");

    // R5: bus activity with both controls idle
    for (int k = 0; k < 6; k++)
      step(1'b1, 1'b1, 1'b0, 2'(k), 8'(k * 37 + 5), "R5 bus ignored");
    idle(3, "R5 result");

    // R7: shutdown, write and load during it, then release
    step(1'b1, 1'b1, 1'b1, 2'd0, 8'h00, "R7 enter");
    idle(3, "R7 off");
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h80, "R7 load while off");
    idle(3, "R7 off");
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R7 release");
    idle(4, "R7 codes restored");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic w, l, s;
      w = ($urandom_range(0, 2) != 0);
      l = ($urandom_range(0, 3) != 0);
      s = ($urandom_range(0, 15) == 0);
      step(w, l, s, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)), "R8 random");
    end
    step(1'b1, 1'b1, 1'b0, 2'd0, 8'h00, "R9 drain");
    idle(4, "R8 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule